// File: doc/BRIEF.md
# Triggered Timed-Write Sequencer

This block replays a fixed table of timed single-bit writes after a one-cycle start pulse. Each table entry names a cycle offset, an output bit and a constant value. When the pulse is accepted, an internal step counter walks from offset 1 up to the largest offset in the table. At each step, every entry whose offset matches writes its value into the named bit of a registered output vector. A bit keeps its value until a later entry overwrites it. After the last step the block drops its busy flag and stays quiet until the next accepted pulse.

The table is set by parameter arrays when the block is elaborated. The default table drives two bits: bit 0 is set at offset 1, set again at offset 5 and cleared at offset 7. Bit 1 is set at offset 10 and cleared at offset 11. Elaboration rejects a table in any of these cases: an offset below 1, an offset that the counter width cannot hold, an output index outside the vector, or a value other than 0 or 1.

Top module: `timed_write_seq`

## Requirements
- R1: A synchronous reset, whether applied at start-up or in the middle of a run, sets every output bit to 0 and busy to 0 in the cycle that follows.
- R2: While idle and with no start pulse, the output vector and busy keep their values for any number of cycles.
- R3: A start pulse sampled high for one rising edge while idle raises busy from the next cycle and runs the whole table.
- R4: An entry with offset k takes effect at the k-th rising edge after the edge that sampled the start pulse. Its value is visible in the cycle after that edge.
- R5: With the default table (offsets 1,5,7,10,11; bits 0,0,0,1,1; values 1,1,0,1,0), bit 0 reads 1 after offsets 1 through 6 and 0 after offset 7. Bit 1 reads 1 only after offset 10.
- R6: Between matching entries each bit holds its last written value. Writing a value that a bit already holds leaves it unchanged.
- R7: Busy stays high for exactly as many cycles as the largest offset, then falls. No output changes after that while no pulse arrives.
- R8: A start pulse sampled while busy is high is ignored, including one sampled at the edge of the final step.
- R9: A start pulse after completion replays the table from offset 1, starting from the values the bits hold at that point.
- R10: When two entries share both an offset and an output bit, the entry listed later in the table decides the value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_pulse | input | 1 | Start request, sampled on the rising edge |
| busy | output | 1 | High while the table is being replayed |
| evt_out | output | NUM_OUT | Registered output bits written by the table |

## Verification
A wrong step count shows up as an output bit changing one cycle early or late. It also shows up as busy falling at the wrong time. The bench compares every output bit and busy against an arithmetic model at every cycle of every run, so such an error is reported in the cycle it first appears. A start pulse that leaks through while busy would restart the counter. Within a few cycles, an entry would then fire a second time or busy would stay high past the last offset. A wrong merge rule for duplicate entries shows up at the single step where a second configuration holds two entries for the same bit at the same offset.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        logic en;
        logic val;
    } bit_wr_t;

    function automatic bit offset_fits(input int ofs, input int cnt_w);
        return (ofs >= 1) && (ofs <= (1 << cnt_w) - 1);
    endfunction

    function automatic bit index_fits(input int idx, input int n_out);
        return (idx >= 0) && (idx < n_out);
    endfunction

    function automatic bit value_fits(input int v);
        return (v == 0) || (v == 1);
    endfunction

endpackage

// File: rtl/tws_step_timer.sv
module tws_step_timer
    import tws_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int LAST_OFS = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_pulse,
    output logic             running,
    output logic [CNT_W-1:0] step
);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LAST_OFS);
    localparam logic [CNT_W-1:0] FIRST_C = CNT_W'(1);

    phase_e           phase_q;
    logic [CNT_W-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start_pulse) begin
                        phase_q <= PH_RUN;
                        step_q  <= FIRST_C;
                    end
                end
                PH_RUN: begin
                    if (step_q == LAST_C) begin
                        phase_q <= PH_IDLE;
                        step_q  <= '0;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                    step_q  <= '0;
                end
            endcase
        end
    end

    assign running = (phase_q == PH_RUN);
    assign step    = step_q;

    // R3: an idle start is accepted and counting begins at offset 1
    assert_start_accept_R3: assert property (@(posedge clk) disable iff (rst)
        (!running && start_pulse) |=> (running && step == FIRST_C));

    // R8: start while running never disturbs the count
    assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (rst)
        (running && step != LAST_C) |=> (running && step == $past(step) + 1'b1));

    // R7: the run ends right after the final step
    assert_run_ends_R7: assert property (@(posedge clk) disable iff (rst)
        (running && step == LAST_C) |=> !running);

    // R7: step stays inside the table's range while running
    assert_step_range_R7: assert property (@(posedge clk) disable iff (rst)
        running |-> (step >= FIRST_C && step <= LAST_C));

endmodule

// File: rtl/tws_event_match.sv
module tws_event_match
    import tws_pkg::*;
#(
    parameter int NUM_OUT = 2,
    parameter int NUM_EV  = 5,
    parameter int CNT_W   = 4,
    parameter int EV_OFS [NUM_EV] = '{1, 5, 7, 10, 11},
    parameter int EV_IDX [NUM_EV] = '{0, 0, 0, 1, 1},
    parameter int EV_VAL [NUM_EV] = '{1, 1, 0, 1, 0}
) (
    input  logic                      running,
    input  logic [CNT_W-1:0]          step,
    output bit_wr_t [NUM_OUT-1:0]     wr
);
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_bit
        always_comb begin
            wr[o].en  = 1'b0;
            wr[o].val = 1'b0;
            // Walk the table in order so a later entry overrides an earlier one
            for (int e = 0; e < NUM_EV; e++) begin
                if (running && (EV_IDX[e] == o) && (step == CNT_W'(EV_OFS[e]))) begin
                    wr[o].en  = 1'b1;
                    wr[o].val = (EV_VAL[e] != 0);
                end
            end
        end
    end

endmodule

// File: rtl/tws_out_regs.sv
module tws_out_regs
    import tws_pkg::*;
#(
    parameter int NUM_OUT = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  running,
    input  bit_wr_t [NUM_OUT-1:0] wr,
    output logic [NUM_OUT-1:0]    q
);
    logic [NUM_OUT-1:0] q_r;

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q_r[o] <= 1'b0;
            end else if (wr[o].en) begin
                q_r[o] <= wr[o].val;
            end
        end

        // R4: a matched write lands on its bit at the following edge
        assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
            wr[o].en |=> (q[o] == $past(wr[o].val)));
    end

    assign q = q_r;

    // R2: nothing reaches the registers while no run is in progress
    assert_idle_stable_R2: assert property (@(posedge clk) disable iff (rst)
        !running |=> $stable(q));

endmodule

// File: rtl/timed_write_seq.sv
module timed_write_seq
    import tws_pkg::*;
#(
    parameter int NUM_OUT = 2,
    parameter int NUM_EV  = 5,
    parameter int CNT_W   = 4,
    parameter int EV_OFS [NUM_EV] = '{1, 5, 7, 10, 11},
    parameter int EV_IDX [NUM_EV] = '{0, 0, 0, 1, 1},
    parameter int EV_VAL [NUM_EV] = '{1, 1, 0, 1, 0}
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_pulse,
    output logic               busy,
    output logic [NUM_OUT-1:0] evt_out
);
    function automatic int largest_offset();
        int m = 0;
        for (int e = 0; e < NUM_EV; e++) begin
            if (EV_OFS[e] > m) m = EV_OFS[e];
        end
        return m;
    endfunction

    localparam int LAST_OFS = largest_offset();

    for (genvar e = 0; e < NUM_EV; e++) begin : g_check
        if (!offset_fits(EV_OFS[e], CNT_W)) begin : g_bad_ofs
            $error("timed_write_seq: table offset out of range for counter width");
        end
        if (!index_fits(EV_IDX[e], NUM_OUT)) begin : g_bad_idx
            $error("timed_write_seq: table output index out of range");
        end
        if (!value_fits(EV_VAL[e])) begin : g_bad_val
            $error("timed_write_seq: table value must be 0 or 1");
        end
    end

    logic                  running;
    logic [CNT_W-1:0]      step;
    bit_wr_t [NUM_OUT-1:0] wr;

    tws_step_timer #(
        .CNT_W    (CNT_W),
        .LAST_OFS (LAST_OFS)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .start_pulse (start_pulse),
        .running     (running),
        .step        (step)
    );

    tws_event_match #(
        .NUM_OUT (NUM_OUT),
        .NUM_EV  (NUM_EV),
        .CNT_W   (CNT_W),
        .EV_OFS  (EV_OFS),
        .EV_IDX  (EV_IDX),
        .EV_VAL  (EV_VAL)
    ) u_match (
        .running (running),
        .step    (step),
        .wr      (wr)
    );

    tws_out_regs #(
        .NUM_OUT (NUM_OUT)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .running (running),
        .wr      (wr),
        .q       (evt_out)
    );

    assign busy = running;

endmodule

// File: tb/tb_timed_write_seq.sv
`timescale 1ns/1ps
module tb_timed_write_seq;

    // Default table (dut)
    localparam int N1 = 2;
    localparam int E1 = 5;
    localparam int L1 = 11;
    localparam int O1 [E1] = '{1, 5, 7, 10, 11};
    localparam int I1 [E1] = '{0, 0, 0, 1, 1};
    localparam int V1 [E1] = '{1, 1, 0, 1, 0};

    // Second table with a duplicate offset/bit pair (dut_dup)
    localparam int N2 = 3;
    localparam int E2 = 6;
    localparam int L2 = 6;
    localparam int O2 [E2] = '{2, 2, 4, 4, 6, 6};
    localparam int I2 [E2] = '{0, 2, 1, 1, 2, 0};
    localparam int V2 [E2] = '{1, 1, 1, 0, 0, 1};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_pulse = 1'b0;
    logic          busy1, busy2;
    logic [N1-1:0] out1;
    logic [N2-1:0] out2;

    logic [N1-1:0] exp1;
    logic [N2-1:0] exp2;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    timed_write_seq dut (
        .clk (clk), .rst (rst), .start_pulse (start_pulse),
        .busy (busy1), .evt_out (out1)
    );

    timed_write_seq #(
        .NUM_OUT (N2), .NUM_EV (E2), .CNT_W (3),
        .EV_OFS (O2), .EV_IDX (I2), .EV_VAL (V2)
    ) dut_dup (
        .clk (clk), .rst (rst), .start_pulse (start_pulse),
        .busy (busy2), .evt_out (out2)
    );

    task automatic chk(input string tag, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    // Apply the table entries for step j in listed order (later entries win)
    task automatic model_step(input int j);
        for (int e = 0; e < E1; e++)
            if (O1[e] == j) exp1[I1[e]] = V1[e][0];
        for (int e = 0; e < E2; e++)
            if (O2[e] == j) exp2[I2[e]] = V2[e][0];
    endtask

    task automatic check_all(input string tag, input bit b1, input bit b2);
        chk({tag, " out"}, int'(out1), int'(exp1));
        chk({tag, " dup out"}, int'(out2), int'(exp2));
        chk({tag, " busy"}, int'(busy1), int'(b1));
        chk({tag, " dup busy"}, int'(busy2), int'(b2));
    endtask

    // One run of the table; noise > 0 holds start high for the edge of step 'noise'
    task automatic run_seq(input int noise);
        @(negedge clk);
        start_pulse = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_pulse = 1'b0;
        check_all("R3 start accepted", 1'b1, 1'b1);
        for (int j = 1; j <= L1; j++) begin
            start_pulse = (j == noise);
            @(posedge clk);
            @(negedge clk);
            start_pulse = 1'b0;
            model_step(j);
            if (j == noise)
                check_all("R8 start during busy ignored", j < L1, j < L2);
            else if (j == 4)
                check_all("R10 later entry wins", j < L1, j < L2);
            else if (j == 5 || j == 6)
                check_all("R6 hold and rewrite", j < L1, j < L2);
            else
                check_all("R4 R5 step timing", j < L1, j < L2);
        end
        for (int k = 0; k < 6; k++) begin
            @(posedge clk);
            @(negedge clk);
            check_all("R7 quiet after last step", 1'b0, 1'b0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        exp1 = '0;
        exp2 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset state", 1'b0, 1'b0);

        for (int k = 0; k < 100; k++) begin
            @(posedge clk);
            @(negedge clk);
            check_all("R2 idle without start", 1'b0, 1'b0);
        end

        // First run, then replays with a stray start at every busy step
        for (int r = 0; r <= L2; r++) begin
            run_seq(r);
            chk("R9 replay final bit0", int'(out1[0]), 0);
            chk("R9 replay dup final", int'(out2), 3'b001);
        end

        // Reset in the middle of a run
        @(negedge clk);
        start_pulse = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_pulse = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R4 mid-run bit0 set", int'(out1[0]), 1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp1 = '0;
        exp2 = '0;
        check_all("R1 reset mid-run", 1'b0, 1'b0);
        for (int k = 0; k < 20; k++) begin
            @(posedge clk);
            @(negedge clk);
            check_all("R2 idle after reset", 1'b0, 1'b0);
        end

        // Fresh run after reset
        run_seq(0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule